// File: doc/BRIEF.md
# Flash Erase Command Controller

This block sits between a host write bus and a block-erasable flash array. It turns bus write cycles into erase operations. Each write carries a command byte and an address. An erase only starts after a setup write followed by a confirm write. A single-block erase targets the block that holds the confirm address. A whole-chip erase visits every block in ascending order. It skips blocks that are locked, or that are boot blocks while the write-protect pin is low. It stops at the first block where the programming voltage has gone invalid. The array itself is outside the block: the controller only pulses an erase strobe with a block index, once per erased block, when that block's modelled erase time has run out.

A status byte records completion and four sticky error flags. The error flags stay set until a clear command arrives. The read port returns this status byte in three cases: after an erase command, while an operation is busy, and on request. In array mode, reads pass through the array's data. The ready output is low for the whole of an erase.

Top module: `flash_cmd_ctrl`

## Requirements
- R1: After reset, `ready` is 1, `rd_status` is 0, `rd_data` equals `array_rdata`, and the status byte is 0x80.
- R2: A write of 0x20 followed by a write of 0xD0 erases the block addressed by the confirm write (block = address >> OFFSET_BITS). `ready` falls in the cycle after the confirm and stays low for ERASE_CYCLES cycles. In the last of those cycles, `erase_fire` is 1 and `erase_blk` names the block. `ready` then returns to 1.
- R3: After either setup code (0x20 or 0x30), any write other than 0xD0 sets status bits 4 and 5. It erases nothing and returns the controller to idle.
- R4: If `vpp_ok` is 0 when a block erase is confirmed, status bits 3 and 5 are set. Nothing is erased, and `ready` stays 1.
- R5: A block erase whose target has its `lock` bit set, or whose target is a boot block (index < BOOT_BLOCKS) while `wp_n` is 0, sets status bits 1 and 5 and erases nothing.
- R6: A write of 0x30 followed by 0xD0 starts a whole-chip erase. For each block, from index 0 upward, the controller spends one evaluation cycle. Blocks that R5 would refuse are skipped silently. Every other block gets ERASE_CYCLES busy cycles and one `erase_fire` pulse.
- R7: During a whole-chip erase, if `vpp_ok` is 0 in a block's evaluation cycle, status bits 3 and 5 are set. The walk stops, and no later block is erased.
- R8: Status bits 5, 4, 3 and 1 stay set through later commands and later successful erases. They clear only on command 0x50 written while idle, whatever the value of `vpp_ok`.
- R9: While `ready` is 0, all writes are ignored. `rd_status` is 1, and `rd_data` shows the status byte with bit 7 at 0.
- R10: While idle, 0xFF selects array mode (`rd_data` = `array_rdata`) and 0x70 selects status mode. Both erase setup codes and the confirm also select status mode.
- R11: The status byte has these fields: bit 7 = ready, bit 5 = erase failed, bit 4 = bad command sequence, bit 3 = voltage fault, bit 1 = lock refusal. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Bus write strobe, one cycle per command |
| wr_addr | input | ADDR_W | Write address; the upper BLK_BITS select the block |
| wr_data | input | 8 | Command byte |
| vpp_ok | input | 1 | Programming voltage above lockout level |
| wp_n | input | 1 | Write-protect pin, high permits boot block erase |
| lock | input | NUM_BLOCKS | Per-block lock bits |
| array_rdata | input | 8 | Read data from the array |
| rd_data | output | 8 | Read data: status byte or array data |
| rd_status | output | 1 | Read port currently shows status |
| ready | output | 1 | Ready (1) / busy (0) |
| erase_fire | output | 1 | One-cycle strobe: erase block `erase_blk` now |
| erase_blk | output | BLK_BITS | Index of the block being erased |

## Verification
Command decoding and error reporting take effect one clock after the write is sampled. An error code, a change of read mode, or the start of busy can be seen at the first falling edge after the writing rising edge. An erase strobe arrives ERASE_CYCLES cycles after the confirm. In a whole-chip erase, each block adds one evaluation cycle first, so block k fires after (k+1) evaluation cycles plus (k+1) erase windows when no block is skipped. The bench keeps to these times with a behavioural reference that advances on every rising edge, using the same sampled inputs as the design. It compares ready, read mode, read data and strobe with index on every falling edge. Explicit checks at the end of each scenario confirm the order of erased blocks and the final status codes.

// File: rtl/fcui_pkg.sv
package fcui_pkg;

  localparam logic [7:0] OP_BLK_SETUP   = 8'h20;
  localparam logic [7:0] OP_CHIP_SETUP  = 8'h30;
  localparam logic [7:0] OP_CONFIRM     = 8'hD0;
  localparam logic [7:0] OP_CLEAR       = 8'h50;
  localparam logic [7:0] OP_READ_ARRAY  = 8'hFF;
  localparam logic [7:0] OP_READ_STATUS = 8'h70;

  // status byte field positions
  localparam int SB_READY = 7;
  localparam int SB_ERASE = 5;
  localparam int SB_SEQ   = 4;
  localparam int SB_VOLT  = 3;
  localparam int SB_LOCK  = 1;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_BLK_SETUP,
    CMD_CHIP_SETUP,
    CMD_CONFIRM,
    CMD_CLEAR,
    CMD_RD_ARRAY,
    CMD_RD_STATUS,
    CMD_OTHER
  } cmd_e;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_SETUP_BLK,
    SQ_SETUP_CHIP,
    SQ_PICK,
    SQ_ERASE
  } seq_e;

  function automatic cmd_e decode_op(input logic valid, input logic [7:0] op);
    if (!valid) return CMD_NONE;
    case (op)
      OP_BLK_SETUP:   return CMD_BLK_SETUP;
      OP_CHIP_SETUP:  return CMD_CHIP_SETUP;
      OP_CONFIRM:     return CMD_CONFIRM;
      OP_CLEAR:       return CMD_CLEAR;
      OP_READ_ARRAY:  return CMD_RD_ARRAY;
      OP_READ_STATUS: return CMD_RD_STATUS;
      default:        return CMD_OTHER;
    endcase
  endfunction

  // a block may be erased when unlocked and, for boot blocks, the pin permits it
  function automatic logic erase_permitted(input logic locked, input logic boot,
                                           input logic wp_high);
    return !locked && (!boot || wp_high);
  endfunction

endpackage

// File: rtl/fcui_decoder.sv
module fcui_decoder
  import fcui_pkg::*;
(
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output cmd_e       cmd
);

  always_comb cmd = decode_op(wr_en, wr_data);

endmodule

// File: rtl/fcui_sequencer.sv
module fcui_sequencer
  import fcui_pkg::*;
#(
  parameter int NUM_BLOCKS   = 8,
  parameter int BLK_BITS     = 3,
  parameter int BOOT_BLOCKS  = 2,
  parameter int ERASE_CYCLES = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  cmd_e                  cmd,
  input  logic [BLK_BITS-1:0]   confirm_blk,
  input  logic                  vpp_ok,
  input  logic                  wp_n,
  input  logic [NUM_BLOCKS-1:0] lock,
  output logic                  busy,
  output logic                  fire,
  output logic [BLK_BITS-1:0]   idx,
  output logic                  chip_mode,
  output logic                  ev_seq,
  output logic                  ev_volt,
  output logic                  ev_lock,
  output logic                  ev_clear,
  output logic                  to_status,
  output logic                  to_array
);

  localparam int CW = (ERASE_CYCLES > 1) ? $clog2(ERASE_CYCLES) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(ERASE_CYCLES - 1);
  localparam logic [BLK_BITS-1:0] TOP_BLK = BLK_BITS'(NUM_BLOCKS - 1);

  seq_e                st, st_n;
  logic [CW-1:0]       cnt, cnt_n;
  logic [BLK_BITS-1:0] idx_n;
  logic                chip_n;

  function automatic logic is_boot(input logic [BLK_BITS-1:0] b);
    return int'(b) < BOOT_BLOCKS;
  endfunction

  logic confirm_ok, pick_ok;
  assign confirm_ok = erase_permitted(lock[confirm_blk], is_boot(confirm_blk), wp_n);
  assign pick_ok    = erase_permitted(lock[idx], is_boot(idx), wp_n);

  always_comb begin
    st_n      = st;
    cnt_n     = cnt;
    idx_n     = idx;
    chip_n    = chip_mode;
    ev_seq    = 1'b0;
    ev_volt   = 1'b0;
    ev_lock   = 1'b0;
    ev_clear  = 1'b0;
    to_status = 1'b0;
    to_array  = 1'b0;
    unique case (st)
      SQ_IDLE: begin
        case (cmd)
          CMD_BLK_SETUP:  begin st_n = SQ_SETUP_BLK;  to_status = 1'b1; end
          CMD_CHIP_SETUP: begin st_n = SQ_SETUP_CHIP; to_status = 1'b1; end
          CMD_CLEAR:      ev_clear = 1'b1;
          CMD_RD_ARRAY:   to_array = 1'b1;
          CMD_RD_STATUS:  to_status = 1'b1;
          default: ;
        endcase
      end
      SQ_SETUP_BLK, SQ_SETUP_CHIP: begin
        if (cmd != CMD_NONE) begin
          to_status = 1'b1;
          st_n      = SQ_IDLE;
          if (cmd != CMD_CONFIRM) begin
            ev_seq = 1'b1;
          end else if (st == SQ_SETUP_CHIP) begin
            chip_n = 1'b1;
            idx_n  = '0;
            st_n   = SQ_PICK;
          end else begin
            chip_n = 1'b0;
            idx_n  = confirm_blk;
            if (!vpp_ok) begin
              ev_volt = 1'b1;
            end else if (!confirm_ok) begin
              ev_lock = 1'b1;
            end else begin
              st_n  = SQ_ERASE;
              cnt_n = CNT_LAST;
            end
          end
        end
      end
      SQ_PICK: begin
        if (!vpp_ok) begin
          ev_volt = 1'b1;
          st_n    = SQ_IDLE;
        end else if (!pick_ok) begin
          if (idx == TOP_BLK) st_n = SQ_IDLE;
          else                idx_n = idx + 1'b1;
        end else begin
          st_n  = SQ_ERASE;
          cnt_n = CNT_LAST;
        end
      end
      SQ_ERASE: begin
        if (cnt == '0) begin
          if (chip_mode && idx != TOP_BLK) begin
            idx_n = idx + 1'b1;
            st_n  = SQ_PICK;
          end else begin
            st_n = SQ_IDLE;
          end
        end else begin
          cnt_n = cnt - 1'b1;
        end
      end
      default: st_n = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      cnt       <= '0;
      idx       <= '0;
      chip_mode <= 1'b0;
    end else begin
      st        <= st_n;
      cnt       <= cnt_n;
      idx       <= idx_n;
      chip_mode <= chip_n;
    end
  end

  assign busy = (st == SQ_PICK) || (st == SQ_ERASE);
  assign fire = (st == SQ_ERASE) && (cnt == '0);

endmodule

// File: rtl/fcui_status.sv
module fcui_status
  import fcui_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       ev_seq,
  input  logic       ev_volt,
  input  logic       ev_lock,
  input  logic       ev_clear,
  output logic [7:0] sr
);

  localparam int NFLAGS = 4;

  logic [NFLAGS-1:0] flag_set;
  logic [NFLAGS-1:0] flag_q;

  // order: lock, volt, seq, erase
  assign flag_set = {ev_seq | ev_volt | ev_lock, ev_seq, ev_volt, ev_lock};

  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flag_q[i] <= 1'b0;
      else if (flag_set[i]) flag_q[i] <= 1'b1;
      else if (ev_clear)    flag_q[i] <= 1'b0;
    end
  end

  always_comb begin
    sr           = '0;
    sr[SB_READY] = ~busy;
    sr[SB_ERASE] = flag_q[3];
    sr[SB_SEQ]   = flag_q[2];
    sr[SB_VOLT]  = flag_q[1];
    sr[SB_LOCK]  = flag_q[0];
  end

endmodule

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import fcui_pkg::*;
#(
  parameter int BLK_BITS     = 3,
  parameter int OFFSET_BITS  = 4,
  parameter int BOOT_BLOCKS  = 2,
  parameter int ERASE_CYCLES = 12,
  localparam int NUM_BLOCKS  = 1 << BLK_BITS,
  localparam int ADDR_W      = BLK_BITS + OFFSET_BITS
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [7:0]            wr_data,
  input  logic                  vpp_ok,
  input  logic                  wp_n,
  input  logic [NUM_BLOCKS-1:0] lock,
  input  logic [7:0]            array_rdata,
  output logic [7:0]            rd_data,
  output logic                  rd_status,
  output logic                  ready,
  output logic                  erase_fire,
  output logic [BLK_BITS-1:0]   erase_blk
);

  cmd_e                cmd;
  logic [BLK_BITS-1:0] confirm_blk;
  logic                busy, chip_mode;
  logic                ev_seq, ev_volt, ev_lock, ev_clear;
  logic                to_status, to_array;
  logic [7:0]          sr;
  logic                mode_q;

  assign confirm_blk = BLK_BITS'(wr_addr >> OFFSET_BITS);

  fcui_decoder u_dec (
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .cmd     (cmd)
  );

  fcui_sequencer #(
    .NUM_BLOCKS   (NUM_BLOCKS),
    .BLK_BITS     (BLK_BITS),
    .BOOT_BLOCKS  (BOOT_BLOCKS),
    .ERASE_CYCLES (ERASE_CYCLES)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .confirm_blk (confirm_blk),
    .vpp_ok      (vpp_ok),
    .wp_n        (wp_n),
    .lock        (lock),
    .busy        (busy),
    .fire        (erase_fire),
    .idx         (erase_blk),
    .chip_mode   (chip_mode),
    .ev_seq      (ev_seq),
    .ev_volt     (ev_volt),
    .ev_lock     (ev_lock),
    .ev_clear    (ev_clear),
    .to_status   (to_status),
    .to_array    (to_array)
  );

  fcui_status u_sr (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy     (busy),
    .ev_seq   (ev_seq),
    .ev_volt  (ev_volt),
    .ev_lock  (ev_lock),
    .ev_clear (ev_clear),
    .sr       (sr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         mode_q <= 1'b0;
    else if (to_status) mode_q <= 1'b1;
    else if (to_array)  mode_q <= 1'b0;
  end

  assign ready     = ~busy;
  assign rd_status = busy | mode_q;
  assign rd_data   = rd_status ? sr : array_rdata;

endmodule

// File: rtl/fcui_checker.sv
module fcui_checker #(
  parameter int NUM_BLOCKS  = 8,
  parameter int BLK_BITS    = 3,
  parameter int BOOT_BLOCKS = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  ready,
  input logic                  rd_status,
  input logic [7:0]            sr,
  input logic                  erase_fire,
  input logic [BLK_BITS-1:0]   erase_blk,
  input logic                  chip_mode,
  input logic                  ev_clear,
  input logic                  wp_n,
  input logic [NUM_BLOCKS-1:0] lock
);

  p_busy_reads_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> rd_status);

  p_fire_only_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |-> !ready);

  p_block_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_fire && !chip_mode) |=> ready);

  p_locked_untouched_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_fire |-> !lock[erase_blk]);

  p_boot_needs_pin_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_fire && (int'(erase_blk) < BOOT_BLOCKS)) |-> wp_n);

  p_seq_pairs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[4]) |-> sr[5]);

  p_volt_pairs_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[3]) |-> sr[5]);

  p_lock_pairs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr[1]) |-> sr[5]);

  p_sticky_erase_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr[5]) |-> $past(ev_clear));

  p_sticky_seq_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr[4]) |-> $past(ev_clear));

  p_sticky_volt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr[3]) |-> $past(ev_clear));

  p_sticky_lock_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr[1]) |-> $past(ev_clear));

  p_ready_bit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sr[7] == ready);

endmodule

bind flash_cmd_ctrl fcui_checker #(
  .NUM_BLOCKS  (NUM_BLOCKS),
  .BLK_BITS    (BLK_BITS),
  .BOOT_BLOCKS (BOOT_BLOCKS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ready      (ready),
  .rd_status  (rd_status),
  .sr         (sr),
  .erase_fire (erase_fire),
  .erase_blk  (erase_blk),
  .chip_mode  (chip_mode),
  .ev_clear   (ev_clear),
  .wp_n       (wp_n),
  .lock       (lock)
);

// File: tb/flash_cmd_ctrl_test.sv
module flash_cmd_ctrl_test;
  localparam int BW = 3, OW = 4, BOOT = 2, EC = 12;
  localparam int NB = 1 << BW, AW = BW + OW;

  logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          vpp_ok = 1'b1, wp_n = 1'b1;
  logic [NB-1:0] lock = '0;
  logic [7:0]    array_rdata = 8'h5A;
  logic [7:0]    rd_data;
  logic          rd_status, ready, erase_fire;
  logic [BW-1:0] erase_blk;

  always #2.5 clk = ~clk;

  flash_cmd_ctrl #(.BLK_BITS(BW), .OFFSET_BITS(OW), .BOOT_BLOCKS(BOOT),
                   .ERASE_CYCLES(EC)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .vpp_ok(vpp_ok), .wp_n(wp_n), .lock(lock),
    .array_rdata(array_rdata), .rd_data(rd_data), .rd_status(rd_status),
    .ready(ready), .erase_fire(erase_fire), .erase_blk(erase_blk));

  int    total = 0, bad = 0;
  string req = "R1";
  int    fired[$];

  task automatic chk(string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference ----------------
  // phase: 0 idle, 1 block setup, 2 chip setup, 3 evaluate, 4 erasing
  int phase = 0, left = 0, cur = 0;
  bit chip = 0, smode = 0, live = 0;
  bit e_er = 0, e_sq = 0, e_vo = 0, e_lk = 0;

  function automatic bit refused(int b);
    return lock[b] || (b < BOOT && !wp_n);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      phase = 0; left = 0; cur = 0; chip = 0; smode = 0;
      e_er = 0; e_sq = 0; e_vo = 0; e_lk = 0; live = 0;
    end else begin
      live = 1;
      case (phase)
        0: if (wr_en) begin
          if (wr_data == 8'h20) begin phase = 1; smode = 1; end
          else if (wr_data == 8'h30) begin phase = 2; smode = 1; end
          else if (wr_data == 8'h50) begin e_er = 0; e_sq = 0; e_vo = 0; e_lk = 0; end
          else if (wr_data == 8'hFF) smode = 0;
          else if (wr_data == 8'h70) smode = 1;
        end
        1, 2: if (wr_en) begin
          smode = 1;
          if (wr_data != 8'hD0) begin e_sq = 1; e_er = 1; phase = 0; end
          else if (phase == 2) begin chip = 1; cur = 0; phase = 3; end
          else begin
            chip = 0; cur = int'(wr_addr) / (1 << OW); phase = 0;
            if (!vpp_ok) begin e_vo = 1; e_er = 1; end
            else if (refused(cur)) begin e_lk = 1; e_er = 1; end
            else begin phase = 4; left = EC - 1; end
          end
        end
        3: begin
          if (!vpp_ok) begin e_vo = 1; e_er = 1; phase = 0; end
          else if (refused(cur)) begin
            if (cur == NB - 1) phase = 0; else cur++;
          end else begin phase = 4; left = EC - 1; end
        end
        default: begin
          if (left == 0) begin
            if (chip && cur != NB - 1) begin cur++; phase = 3; end
            else phase = 0;
          end else left--;
        end
      endcase
    end
  end

  function automatic int exp_status();
    int s;
    s = (phase < 3) ? 8'h80 : 0;
    if (e_er) s |= 8'h20;
    if (e_sq) s |= 8'h10;
    if (e_vo) s |= 8'h08;
    if (e_lk) s |= 8'h02;
    return s;
  endfunction

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && live) begin
      bit rs, fx;
      rs = (phase >= 3) || smode;
      fx = (phase == 4) && (left == 0);
      chk("ready", int'(ready), int'(phase < 3));
      chk("rd_status", int'(rd_status), int'(rs));
      chk("rd_data", int'(rd_data), rs ? exp_status() : int'(array_rdata));
      chk("erase_fire", int'(erase_fire), int'(fx));
      if (fx) chk("erase_blk", int'(erase_blk), cur);
    end
    if (rst_n && erase_fire) fired.push_back(int'(erase_blk));
  end

  // ---------------- stimulus ----------------
  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_ready();
    for (int i = 0; i < 4000 && !ready; i++) @(negedge clk);
  endtask

  task automatic blk_erase(input int b);
    wr(0, 8'h20);
    wr(b << OW, 8'hD0);
    wait_ready();
  endtask

  initial begin
    #(5.0 * 150000);
    total++; bad++;
    $display("FAIL R9 watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    req = "R1";
    chk("reset ready", int'(ready), 1);
    chk("reset rd_status", int'(rd_status), 0);
    chk("reset rd_data", int'(rd_data), 8'h5A);

    // R2 block erase, R9 writes ignored while busy
    req = "R2";
    wr(0, 8'h20);
    wr(5 << OW, 8'hD0);
    chk("busy after confirm", int'(ready), 0);
    req = "R9";
    wr(0, 8'h50);
    wr(0, 8'hFF);
    chk("status while busy", int'(rd_status), 1);
    chk("bit7 while busy", int'(rd_data[7]), 0);
    wait_ready();
    req = "R2";
    chk("one block erased", fired.size(), 1);
    chk("block index", fired[fired.size()-1], 5);
    chk("status after erase", int'(rd_data), 8'h80);

    // R10 read modes
    req = "R10";
    wr(0, 8'hFF);
    chk("array mode", int'(rd_data), 8'h5A);
    wr(0, 8'h70);
    chk("status mode", int'(rd_data), 8'h80);

    // R3 bad sequences
    req = "R3";
    fired.delete();
    wr(0, 8'h20);
    wr(3 << OW, 8'h40);
    chk("seq error block", int'(rd_data), 8'hB0);
    wr(0, 8'h50);
    wr(0, 8'h30);
    wr(0, 8'h20);
    chk("seq error chip", int'(rd_data), 8'hB0);
    chk("nothing erased", fired.size(), 0);

    // R8 sticky through a good erase, then clear
    req = "R8";
    blk_erase(6);
    chk("sticky after erase", int'(rd_data), 8'hB0);
    chk("erase still ran", fired.size(), 1);
    wr(0, 8'h50);
    chk("cleared", int'(rd_data), 8'h80);

    // R4 voltage low at confirm; R8 clear with voltage low
    req = "R4";
    fired.delete();
    vpp_ok = 1'b0;
    wr(0, 8'h20);
    wr(4 << OW, 8'hD0);
    chk("no busy", int'(ready), 1);
    chk("volt error", int'(rd_data), 8'hA8);
    chk("nothing erased", fired.size(), 0);
    req = "R8";
    wr(0, 8'h50);
    chk("clear with vpp low", int'(rd_data), 8'h80);
    vpp_ok = 1'b1;

    // R5 lock and boot protection
    req = "R5";
    lock[3] = 1'b1;
    blk_erase(3);
    chk("locked block", int'(rd_data), 8'hA2);
    wr(0, 8'h50);
    lock = '0;
    wp_n = 1'b0;
    blk_erase(0);
    chk("boot with wp low", int'(rd_data), 8'hA2);
    chk("nothing erased", fired.size(), 0);
    wr(0, 8'h50);
    wp_n = 1'b1;
    blk_erase(0);
    chk("boot with wp high", int'(rd_data), 8'h80);
    chk("boot block erased", fired.size(), 1);

    // R6 chip erase skipping locked and protected boot blocks
    req = "R6";
    fired.delete();
    wp_n = 1'b0;
    lock = NB'(8'b0000_0100);
    wr(0, 8'h30);
    wr(0, 8'hD0);
    wait_ready();
    chk("count erased", fired.size(), 5);
    for (int k = 0; k < 5 && k < fired.size(); k++) chk("order", fired[k], k + 3);
    chk("chip status", int'(rd_data), 8'h80);
    wp_n = 1'b1;
    lock = '0;

    // R7 chip erase halts when voltage drops
    req = "R7";
    fired.delete();
    wr(0, 8'h30);
    wr(0, 8'hD0);
    for (int i = 0; i < 4000 && !(erase_fire && erase_blk == BW'(1)); i++) @(negedge clk);
    vpp_ok = 1'b0;
    wait_ready();
    @(negedge clk);
    chk("halted count", fired.size(), 2);
    chk("halt status", int'(rd_data), 8'hA8);
    vpp_ok = 1'b1;
    wr(0, 8'h50);
    req = "R11";
    chk("status layout idle", int'(rd_data), 8'h80);
    repeat (3) @(negedge clk);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule